// File: doc/BRIEF.md
# Byte-Wide Access Bridge for Wide Timer Registers

This bridge sits between an 8-bit processor bus and a group of 16-bit peripheral registers: a free-running counter, a set of compare registers and a capture register. Since the bus moves one byte at a time, the bridge pairs two byte accesses into one atomic 16-bit operation. It does this with a single 8-bit holding latch that every 16-bit register in the group shares.

For a write, software first puts the upper byte into the holding latch. The lower-byte write then commits both bytes to the target in one cycle, through a one-hot update strobe and a 16-bit update word. For a read of the counter or the capture register, the lower-byte read also saves the register's upper half in the holding latch. The later upper-byte read returns that saved byte, so the two halves form a coherent snapshot even while the counter keeps moving. Compare registers are treated differently. Both of their bytes are read directly and the latch is left untouched. Because all registers share one latch, software must not interleave two 16-bit sequences. The bridge does not guard against this.

Top module: `bytebr_top`

## Requirements
- R1: After reset, `rdata_o` is 0, every bit of `upd_strobe_o` is 0, and the holding latch holds 0. Reading the counter's upper byte before any other access therefore returns 0.
- R2: A write to the upper-byte address of any mapped register loads only the holding latch. No update strobe fires.
- R3: A write to the lower-byte address of register k sets `upd_strobe_o[k]` alone for exactly one cycle, in the cycle after the write. In that cycle `upd_data_o` equals {holding latch, written byte}.
- R4: A read of the lower byte of the counter or capture register returns bits [7:0] and copies bits [15:8] into the holding latch on the same edge.
- R5: Reads of either byte of a compare register return that register's own bits, [7:0] or [15:8]. They leave the holding latch unchanged.
- R6: A read of the upper byte of the counter or capture register returns the holding latch, not the register's live value.
- R7: The holding latch is shared. Any upper-byte write or temp-loading read made between another register's upper-byte write and lower-byte write changes what that register receives.
- R8: Register k has its lower byte at address 2k and its upper byte at address 2k+1. Index 0 is the counter, indices 1..NUM_CMP are the compare registers, and index NUM_CMP+1 is the capture register. Reads from unmapped addresses return 0. Writes to unmapped addresses fire no strobe and leave the latch unchanged.
- R9: Read data is registered. It is valid in the cycle after a read strobe and is 0 in any cycle not preceded by a read. When write and read are asserted together, the write is performed and the read is dropped, so `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write byte |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| cnt_val_i | input | 16 | Current counter value |
| cmp_val_i | input | 16*NUM_CMP | Compare register values, index 1 in the low bits |
| cap_val_i | input | 16 | Current capture register value |
| rdata_o | output | 8 | Registered read byte |
| upd_strobe_o | output | NUM_CMP+2 | One-hot full-width update strobe per register |
| upd_data_o | output | 16 | 16-bit word to load with the strobe |

## Verification
The hardest case to reach is corruption through the shared latch. It needs an open write sequence on one register to be broken by a temp-loading read of a different register, and only then the closing lower-byte write. The stimulus opens a write to a compare register and reads the counter's lower byte while the counter holds a distinctive upper byte. It then closes the write and expects the committed word to carry the counter's byte. The snapshot case is reached by changing the counter input between the lower and upper reads.

// File: rtl/bytebr_pkg.sv
package bytebr_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        KIND_CNT  = 2'd0,
        KIND_CMP  = 2'd1,
        KIND_CAP  = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/bytebr_decode.sv
module bytebr_decode
    import bytebr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_REGS = 5,
    localparam int IDX_W   = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic              hi_o,
    output logic [IDX_W-1:0]  idx_o,
    output reg_kind_e         kind_o
);
    always_comb begin
        idx_o  = addr_i[ADDR_W-1:1];
        hi_o   = addr_i[0];
        hit_o  = (int'(idx_o) < NUM_REGS);
        kind_o = KIND_NONE;
        if (hit_o) begin
            if (idx_o == '0)
                kind_o = KIND_CNT;
            else if (int'(idx_o) == NUM_REGS - 1)
                kind_o = KIND_CAP;
            else
                kind_o = KIND_CMP;
        end
    end
endmodule

// File: rtl/bytebr_rdsel.sv
module bytebr_rdsel
    import bytebr_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int IDX_W    = 3
) (
    input  logic [NUM_REGS*WORD_W-1:0] vals_i,
    input  logic [IDX_W-1:0]           idx_i,
    output logic [WORD_W-1:0]          sel_o
);
    always_comb begin
        sel_o = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (idx_i == IDX_W'(k))
                sel_o = vals_i[k*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/bytebr_temp.sv
module bytebr_temp
    import bytebr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_wr_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              ld_rd_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic [BYTE_W-1:0] temp_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] temp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_wr_i)
            st_d.temp = wr_byte_i;
        else if (ld_rd_i)
            st_d.temp = rd_byte_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign temp_o = st_q.temp;

    // R2: a high-byte write lands in the latch on the next edge
    p_hi_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr_i |=> temp_o == $past(wr_byte_i));
endmodule

// File: rtl/bytebr_top.sv
module bytebr_top
    import bytebr_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_CMP = 3,
    localparam int NUM_REGS = NUM_CMP + 2,
    localparam int IDX_W    = ADDR_W - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [BYTE_W-1:0]         wdata_i,
    input  logic                      wr_en_i,
    input  logic                      rd_en_i,
    input  logic [WORD_W-1:0]         cnt_val_i,
    input  logic [NUM_CMP*WORD_W-1:0] cmp_val_i,
    input  logic [WORD_W-1:0]         cap_val_i,
    output logic [BYTE_W-1:0]         rdata_o,
    output logic [NUM_REGS-1:0]       upd_strobe_o,
    output logic [WORD_W-1:0]         upd_data_o
);
    typedef struct packed {
        logic [BYTE_W-1:0]   rdata;
        logic [NUM_REGS-1:0] strobe;
        logic [WORD_W-1:0]   data;
    } st_t;

    st_t st_d, st_q;

    logic              hit, hi;
    logic [IDX_W-1:0]  idx;
    reg_kind_e         kind;
    logic [WORD_W-1:0] sel_val;
    logic [BYTE_W-1:0] temp_q;
    logic              rd_act, wr_hi, wr_lo, rd_lo_tmp;
    logic [NUM_REGS*WORD_W-1:0] vals;

    assign vals = {cap_val_i, cmp_val_i, cnt_val_i};

    bytebr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) i_decode (
        .addr_i (addr_i),
        .hit_o  (hit),
        .hi_o   (hi),
        .idx_o  (idx),
        .kind_o (kind)
    );

    bytebr_rdsel #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_rdsel (
        .vals_i (vals),
        .idx_i  (idx),
        .sel_o  (sel_val)
    );

    assign rd_act    = rd_en_i && !wr_en_i;
    assign wr_hi     = wr_en_i && hit && hi;
    assign wr_lo     = wr_en_i && hit && !hi;
    assign rd_lo_tmp = rd_act && hit && !hi && (kind != KIND_CMP);

    bytebr_temp i_temp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_wr_i   (wr_hi),
        .wr_byte_i (wdata_i),
        .ld_rd_i   (rd_lo_tmp),
        .rd_byte_i (sel_val[WORD_W-1:BYTE_W]),
        .temp_o    (temp_q)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rdata  = '0;
        st_d.strobe = '0;
        if (rd_act && hit) begin
            if (!hi)
                st_d.rdata = sel_val[BYTE_W-1:0];
            else if (kind == KIND_CMP)
                st_d.rdata = sel_val[WORD_W-1:BYTE_W];
            else
                st_d.rdata = temp_q;
        end
        for (int k = 0; k < NUM_REGS; k++)
            st_d.strobe[k] = wr_lo && (idx == IDX_W'(k));
        if (wr_lo)
            st_d.data = {temp_q, wdata_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o      = st_q.rdata;
    assign upd_strobe_o = st_q.strobe;
    assign upd_data_o   = st_q.data;

    // R3: at most one register updated per cycle
    p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_strobe_o));
    // R3: committed word pairs the latch with the low byte written
    p_commit_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i[0] && int'(addr_i[ADDR_W-1:1]) < NUM_REGS)
        |=> (upd_strobe_o != '0) && upd_data_o == {$past(temp_q), $past(wdata_i)});
    // R5: compare reads never disturb the latch
    p_cmp_read_keeps_temp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !wr_en_i && kind == KIND_CMP) |=> $stable(temp_q));
    // R8: unmapped reads give zero
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !hit) |=> rdata_o == '0);
    // R9: nonzero read data only after an accepted read
    p_rdata_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && !wr_en_i) |=> rdata_o == '0);
endmodule

// File: tb/test_bytebr_top.sv
module test_bytebr_top;
    localparam int ADDR_W = 4;
    localparam int NUM_CMP = 3;
    localparam int NR = NUM_CMP + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] cnt_val = '0, cap_val = '0;
    logic [NUM_CMP*16-1:0] cmp_val = '0;
    logic [7:0] rdata;
    logic [NR-1:0] strobe;
    logic [15:0] upd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bytebr_top #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) i_bytebr_top (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .cnt_val_i(cnt_val),
        .cmp_val_i(cmp_val), .cap_val_i(cap_val), .rdata_o(rdata),
        .upd_strobe_o(strobe), .upd_data_o(upd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bus cycle; outputs sampled 2 ns after the capturing edge
    task automatic cyc(input logic [ADDR_W-1:0] a, input logic w, input logic r, input logic [7:0] d);
        addr = a; wr_en = w; rd_en = r; wdata = d;
        @(posedge clk); #2;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rdata", 32'(rdata), 0);
        chk("R1 strobe", 32'(strobe), 0);
        cyc(4'd1, 0, 1, 8'h00);
        chk("R1 latch zero via counter high", 32'(rdata), 0);
    endtask

    task automatic t_write_all;
        for (int k = 0; k < NR; k++) begin
            cyc(4'(2*k+1), 1, 0, 8'(8'hA0 + k));
            chk("R2 no strobe on high write", 32'(strobe), 0);
            cyc(4'(2*k), 1, 0, 8'(8'h30 + k));
            chk("R3 R8 strobe index", 32'(strobe), 32'(1 << k));
            chk("R3 word", 32'(upd_data), 32'({8'(8'hA0 + k), 8'(8'h30 + k)}));
            cyc(4'd0, 0, 0, 8'h00);
            chk("R3 strobe one cycle", 32'(strobe), 0);
        end
    endtask

    task automatic t_latch_visible;
        cyc(4'd5, 1, 0, 8'h6C);
        cyc(4'd1, 0, 1, 8'h00);
        chk("R2 R6 high write visible in latch", 32'(rdata), 32'h6C);
    endtask

    task automatic t_snapshot;
        cnt_val = 16'h1234;
        cyc(4'd0, 0, 1, 8'h00);
        chk("R4 counter low", 32'(rdata), 32'h34);
        cnt_val = 16'h5678;
        cyc(4'd1, 0, 1, 8'h00);
        chk("R4 R6 counter snapshot high", 32'(rdata), 32'h12);
        cap_val = 16'hC3A5;
        cyc(4'd8, 0, 1, 8'h00);
        chk("R4 capture low", 32'(rdata), 32'hA5);
        cap_val = 16'h0000;
        cyc(4'd9, 0, 1, 8'h00);
        chk("R4 R6 capture snapshot high", 32'(rdata), 32'hC3);
    endtask

    task automatic t_cmp_read;
        cnt_val = 16'h9900;
        cyc(4'd0, 0, 1, 8'h00);
        cmp_val = {16'h1111, 16'hBEEF, 16'h2222};
        cyc(4'd4, 0, 1, 8'h00);
        chk("R5 cmp low", 32'(rdata), 32'hEF);
        cyc(4'd5, 0, 1, 8'h00);
        chk("R5 cmp high direct", 32'(rdata), 32'hBE);
        cyc(4'd7, 0, 1, 8'h00);
        chk("R5 R8 third cmp high", 32'(rdata), 32'h11);
        cyc(4'd1, 0, 1, 8'h00);
        chk("R5 latch untouched", 32'(rdata), 32'h99);
    endtask

    task automatic t_interleave;
        cyc(4'd3, 1, 0, 8'h11);
        cnt_val = 16'h7700;
        cyc(4'd0, 0, 1, 8'h00);
        cyc(4'd2, 1, 0, 8'h22);
        chk("R7 corrupted strobe", 32'(strobe), 32'h2);
        chk("R7 corrupted word", 32'(upd_data), 32'h7722);
    endtask

    task automatic t_unmapped;
        cyc(4'd12, 0, 1, 8'h00);
        chk("R8 unmapped read zero", 32'(rdata), 0);
        cyc(4'd1, 1, 0, 8'h5D);
        cyc(4'd11, 1, 0, 8'hEE);
        chk("R8 unmapped high write no strobe", 32'(strobe), 0);
        cyc(4'd10, 1, 0, 8'h44);
        chk("R8 unmapped low write no strobe", 32'(strobe), 0);
        cyc(4'd1, 0, 1, 8'h00);
        chk("R8 latch unchanged", 32'(rdata), 32'h5D);
    endtask

    task automatic t_both;
        cyc(4'd1, 1, 0, 8'h0F);
        cnt_val = 16'hFFFF;
        addr = 4'd0; wr_en = 1'b1; rd_en = 1'b1; wdata = 8'h55;
        @(posedge clk); #2;
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R9 write wins rdata", 32'(rdata), 0);
        chk("R9 write wins strobe", 32'(strobe), 1);
        chk("R9 write wins word", 32'(upd_data), 32'h0F55);
        cyc(4'd0, 0, 0, 8'h00);
        chk("R9 idle rdata zero", 32'(rdata), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        t_reset();
        t_write_all();
        t_latch_visible();
        t_snapshot();
        t_cmp_read();
        t_interleave();
        t_unmapped();
        t_both();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule